// File: doc/BRIEF.md
# Random qubit symbol pulse sequencer

This block plays a stream of 4-bit qubit symbols out of an on-chip buffer and turns each one into timed drive pulses for an electro-optical transmitter. The core clock runs four cycles per qubit slot. Every slot takes the next buffer entry, and no entry is ever replayed or expanded. Each symbol carries a polarization pair (a basis bit and a value bit) and a two-bit intensity level.

The buffer is split into two equal halves that a host processor writes through a plain write port. When playback leaves a half, the block raises that half's interrupt and drops the half's valid mark. The host can then rewrite the half and mark it valid again while the other half is playing, so transmission goes on without gaps. If playback reaches a half that has not been marked valid, the affected slots stay dark and a sticky underrun flag is set. Dropping the enable input stops playback at the end of the current slot and rewinds the read pointer.

Top module: `qubit_pulse_seq`

## Requirements
- R1: After reset, `pulse`, `sym_bus`, `irq` and `underrun` are all zero.
- R2: A slot lasts SLOT_CYCLES (4) cycles. Its pulses are high for exactly one cycle, two cycles after the slot's fetch cycle, so trigger pulses of back-to-back slots are 4 cycles apart.
- R3: For a played symbol `s`, `pulse[0]` (trigger) is 1, `pulse[1]` equals `s[3]` (basis bit), and `pulse[2]` is 1 when the intensity field `s[1:0]` is nonzero. `s[2]` is the polarization value bit.
- R4: `sym_bus` shows the full played symbol from its pulse cycle until the next slot's update.
- R5: Slots read consecutive addresses, wrapping from 2*HALF_DEPTH-1 to 0. Data the host writes into an address after it was played is what the next pass plays.
- R6: After a slot plays the last address of half h (HALF_DEPTH-1 for half 0, 2*HALF_DEPTH-1 for half 1), `irq[h]` is set and half h loses its valid mark. A one-cycle pulse on `valid_set[h]` marks half h valid again.
- R7: `irq[h]` stays high until a one-cycle pulse on `irq_ack[h]` clears it.
- R8: A slot whose half is not valid produces no pulse on any output and drives `sym_bus` to 0. The read pointer still advances, and `underrun` goes high and stays high until reset, including across stop and restart.
- R9: With `enable` low at the end of a slot, playback stops, no further pulses appear, `irq` is cleared, and the next run starts at address 0. Its first pulse appears within 6 cycles of `enable` rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, four cycles per slot |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Playback run request |
| wr_en | input | 1 | Host buffer write strobe |
| wr_addr | input | $clog2(HALF_DEPTH)+1 | Host write address; the top bit selects the half |
| wr_data | input | 4 | Symbol to write |
| valid_set | input | 2 | Per-half pulse marking the half refilled |
| irq_ack | input | 2 | Per-half interrupt acknowledge pulse |
| irq | output | 2 | Per-half "half emptied" interrupt, level |
| underrun | output | 1 | Sticky flag for playback from an unfilled half |
| pulse | output | 3 | Drive pulses: [0] trigger, [1] basis, [2] intensity |
| sym_bus | output | 4 | Registered copy of the played symbol |

## Verification
On every cycle, the checker enforces that pulses are one cycle wide and fall only in the firing phase of a running slot. It also checks that data pulses never appear without the trigger, that an unacknowledged interrupt does not drop while enabled, and that underrun never clears. Whether the right symbol appears at the right address, that rewritten data replaces the old, and that a crossing raises the interrupt for the correct half can only be shown by the bench's scenarios. The same holds for blanking on an unfilled half and for the rewind after a stop. The bench walks two full passes of the buffer with a mid-run rewrite, then an underrun, a stop and a restart.

// File: rtl/qsym_pkg.sv
package qsym_pkg;

    localparam int SYM_W  = 4;
    localparam int HALVES = 2;

    // Phase indices within a slot
    localparam int PH_FETCH = 0;
    localparam int PH_LOAD  = 1;
    localparam int PH_FIRE  = 2;

    typedef struct packed {
        logic       basis;
        logic       value;
        logic [1:0] level;
    } qsym_t;

    typedef struct packed {
        logic intensity;
        logic basis;
        logic trigger;
    } pulse_t;

    function automatic pulse_t sym_to_pulse(input qsym_t s);
        pulse_t p;
        p.trigger   = 1'b1;
        p.basis     = s.basis;
        p.intensity = |s.level;
        return p;
    endfunction

endpackage

// File: rtl/qsym_buffer.sv
module qsym_buffer #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic [qsym_pkg::SYM_W-1:0] wr_data,
    input  logic                      rd_en,
    input  logic [AW-1:0]             rd_addr,
    output logic [qsym_pkg::SYM_W-1:0] rd_data
);
    logic [qsym_pkg::SYM_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= mem[rd_addr];
        end
    end
endmodule

// File: rtl/qsym_slot_timer.sv
module qsym_slot_timer #(
    parameter int SLOT_CYCLES = 4,
    parameter int PW          = $clog2(SLOT_CYCLES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    output logic          run,
    output logic [PW-1:0] phase,
    output logic          slot_start,
    output logic          stop
);
    localparam logic [PW-1:0] LAST = PW'(SLOT_CYCLES - 1);

    logic slot_end;

    assign slot_end   = run && (phase == LAST);
    assign slot_start = run && (phase == '0);
    assign stop       = slot_end && !enable;

    always_ff @(posedge clk) begin
        if (rst) begin
            run   <= 1'b0;
            phase <= '0;
        end else if (!run) begin
            phase <= '0;
            if (enable) begin
                run <= 1'b1;
            end
        end else if (slot_end) begin
            phase <= '0;
            if (!enable) begin
                run <= 1'b0;
            end
        end else begin
            phase <= phase + 1'b1;
        end
    end
endmodule

// File: rtl/qsym_half_ctrl.sv
module qsym_half_ctrl #(
    parameter int HALF_DEPTH = 8,
    parameter int HW         = $clog2(HALF_DEPTH),
    parameter int AW         = HW + 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          fetch,
    input  logic                          stop,
    input  logic [qsym_pkg::HALVES-1:0]   valid_set,
    input  logic [qsym_pkg::HALVES-1:0]   irq_ack,
    output logic [AW-1:0]                 rd_addr,
    output logic                          slot_ok,
    output logic [qsym_pkg::HALVES-1:0]   irq,
    output logic                          underrun
);
    logic                        cur_half;
    logic                        at_last;
    logic                        crossing;
    logic [qsym_pkg::HALVES-1:0] valid;

    assign cur_half = rd_addr[HW];
    assign at_last  = (rd_addr[HW-1:0] == {HW{1'b1}});
    assign crossing = fetch && at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_addr  <= '0;
            slot_ok  <= 1'b0;
            underrun <= 1'b0;
        end else if (stop) begin
            rd_addr <= '0;
        end else if (fetch) begin
            rd_addr <= rd_addr + 1'b1;
            slot_ok <= valid[cur_half];
            if (!valid[cur_half]) begin
                underrun <= 1'b1;
            end
        end
    end

    for (genvar h = 0; h < qsym_pkg::HALVES; h++) begin : g_half
        logic leaving;
        assign leaving = crossing && (cur_half == 1'(h));

        always_ff @(posedge clk) begin
            if (rst) begin
                valid[h] <= 1'b0;
            end else if (valid_set[h]) begin
                valid[h] <= 1'b1;
            end else if (leaving) begin
                valid[h] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                irq[h] <= 1'b0;
            end else if (stop) begin
                irq[h] <= 1'b0;
            end else if (leaving) begin
                irq[h] <= 1'b1;
            end else if (irq_ack[h]) begin
                irq[h] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/qsym_pulse_out.sv
module qsym_pulse_out (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load,
    input  logic                       fire,
    input  logic                       slot_ok,
    input  logic [qsym_pkg::SYM_W-1:0] sym_in,
    output logic [2:0]                 pulse,
    output logic [qsym_pkg::SYM_W-1:0] sym_bus
);
    import qsym_pkg::*;

    qsym_t  sym;
    pulse_t drive;

    assign sym   = qsym_t'(sym_in);
    assign drive = sym_to_pulse(sym);

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse   <= '0;
            sym_bus <= '0;
        end else if (load) begin
            pulse   <= slot_ok ? 3'(drive) : 3'b000;
            sym_bus <= slot_ok ? sym_in : '0;
        end else if (fire) begin
            pulse <= '0;
        end
    end
endmodule

// File: rtl/qubit_pulse_seq.sv
module qubit_pulse_seq #(
    parameter int HALF_DEPTH  = 8,
    parameter int SLOT_CYCLES = 4
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 enable,
    input  logic                                 wr_en,
    input  logic [$clog2(HALF_DEPTH):0]          wr_addr,
    input  logic [3:0]                           wr_data,
    input  logic [1:0]                           valid_set,
    input  logic [1:0]                           irq_ack,
    output logic [1:0]                           irq,
    output logic                                 underrun,
    output logic [2:0]                           pulse,
    output logic [3:0]                           sym_bus
);
    import qsym_pkg::*;

    localparam int HW    = $clog2(HALF_DEPTH);
    localparam int AW    = HW + 1;
    localparam int DEPTH = HALVES * HALF_DEPTH;
    localparam int PW    = $clog2(SLOT_CYCLES);

    logic          run;
    logic [PW-1:0] phase;
    logic          slot_start;
    logic          stop;
    logic [AW-1:0] rd_addr;
    logic          slot_ok;
    logic [3:0]    rd_data;
    logic          load;
    logic          fire;

    assign load = run && (phase == PW'(PH_LOAD));
    assign fire = run && (phase == PW'(PH_FIRE));

    qsym_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES), .PW(PW)) timer_i (
        .clk(clk), .rst(rst), .enable(enable),
        .run(run), .phase(phase), .slot_start(slot_start), .stop(stop)
    );

    qsym_half_ctrl #(.HALF_DEPTH(HALF_DEPTH), .HW(HW), .AW(AW)) half_i (
        .clk(clk), .rst(rst), .fetch(slot_start), .stop(stop),
        .valid_set(valid_set), .irq_ack(irq_ack),
        .rd_addr(rd_addr), .slot_ok(slot_ok), .irq(irq), .underrun(underrun)
    );

    qsym_buffer #(.DEPTH(DEPTH), .AW(AW)) buf_i (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(slot_start), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    qsym_pulse_out out_i (
        .clk(clk), .rst(rst), .load(load), .fire(fire),
        .slot_ok(slot_ok), .sym_in(rd_data),
        .pulse(pulse), .sym_bus(sym_bus)
    );
endmodule

// File: rtl/qsym_checker.sv
module qsym_checker #(
    parameter int PW = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          enable,
    input logic [1:0]    irq_ack,
    input logic [1:0]    irq,
    input logic          underrun,
    input logic [2:0]    pulse,
    input logic          run,
    input logic [PW-1:0] phase
);
    assert_pulse_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
        (pulse != 3'b000) |=> (pulse == 3'b000));

    assert_pulse_fire_phase_R2: assert property (@(posedge clk) disable iff (rst)
        (pulse != 3'b000) |-> (run && phase == PW'(qsym_pkg::PH_FIRE)));

    assert_data_needs_trigger_R3: assert property (@(posedge clk) disable iff (rst)
        (pulse[2:1] != 2'b00) |-> pulse[0]);

    assert_irq0_held_R7: assert property (@(posedge clk) disable iff (rst)
        (irq[0] && !irq_ack[0] && enable) |=> irq[0]);

    assert_irq1_held_R7: assert property (@(posedge clk) disable iff (rst)
        (irq[1] && !irq_ack[1] && enable) |=> irq[1]);

    assert_underrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        underrun |=> underrun);
endmodule

bind qubit_pulse_seq qsym_checker #(.PW(PW)) chk_i (
    .clk(clk), .rst(rst), .enable(enable), .irq_ack(irq_ack), .irq(irq),
    .underrun(underrun), .pulse(pulse), .run(run), .phase(phase)
);

// File: tb/qubit_pulse_seq_tb_top.sv
module qubit_pulse_seq_tb_top;

    localparam int HALF_DEPTH = 8;
    localparam int AW         = $clog2(HALF_DEPTH) + 1;
    localparam int NSLOT      = 24;

    // {symbol, expected pulse as 4 bits}: first 16 fill the buffer,
    // last 8 are the rewrite of half 0 played on the second pass.
    localparam logic [7:0] VEC [NSLOT] = '{
        8'h01, 8'h15, 8'h25, 8'h35, 8'h41, 8'h55, 8'h65, 8'h75,
        8'h83, 8'h97, 8'hA7, 8'hB7, 8'hC3, 8'hD7, 8'hE7, 8'hF7,
        8'h55, 8'hA7, 8'h35, 8'hC3, 8'h97, 8'h65, 8'hF7, 8'h01
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          enable;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [3:0]    wr_data;
    logic [1:0]    valid_set;
    logic [1:0]    irq_ack;
    logic [1:0]    irq;
    logic          underrun;
    logic [2:0]    pulse;
    logic [3:0]    sym_bus;

    int n_tests = 0;
    int n_fail  = 0;
    int n;

    always #4 clk = ~clk;

    qubit_pulse_seq #(.HALF_DEPTH(HALF_DEPTH), .SLOT_CYCLES(4)) dut_i (
        .clk(clk), .rst(rst), .enable(enable),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .valid_set(valid_set), .irq_ack(irq_ack),
        .irq(irq), .underrun(underrun), .pulse(pulse), .sym_bus(sym_bus)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_pulse(output int cnt);
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
        end while (pulse[0] == 1'b0 && cnt < 20);
    endtask

    task automatic host_idle();
        wr_en     = 1'b0;
        valid_set = 2'b00;
        irq_ack   = 2'b00;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; enable = 1'b0; wr_addr = '0; wr_data = '0;
        host_idle();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(pulse == 3'b000, "R1 pulse", pulse, 0);
        check(sym_bus == 4'h0, "R1 sym_bus", sym_bus, 0);
        check(irq == 2'b00, "R1 irq", irq, 0);
        check(underrun == 1'b0, "R1 underrun", underrun, 0);

        // fill both halves
        for (int a = 0; a < 2 * HALF_DEPTH; a++) begin
            wr_en = 1'b1; wr_addr = AW'(a); wr_data = VEC[a][7:4];
            @(negedge clk);
        end
        wr_en = 1'b0;
        valid_set = 2'b11;
        @(negedge clk);
        valid_set = 2'b00;
        enable = 1'b1;

        for (int i = 0; i < NSLOT; i++) begin
            wait_pulse(n);
            if (i == 0) check(n <= 6, "R9 first slot latency", n, 6);
            else        check(n == 3, "R2 slot spacing", n + 1, 4);
            check(pulse == VEC[i][2:0], "R3 pulse map", pulse, VEC[i][2:0]);
            check(sym_bus == VEC[i][7:4], "R4 R5 sym_bus", sym_bus, VEC[i][7:4]);
            if (i == 7)  check(irq == 2'b01, "R6 irq half0", irq, 1);
            if (i == 8)  check(irq == 2'b00, "R7 ack clears", irq, 0);
            if (i == 15) check(irq == 2'b10, "R6 irq half1", irq, 2);
            if (i == 23) begin
                check(irq == 2'b01, "R6 irq half0 pass2", irq, 1);
                check(underrun == 1'b0, "R8 no false underrun", underrun, 0);
            end
            // host actions, one cycle
            if (i == 7) begin
                irq_ack = 2'b01; valid_set = 2'b01;
            end
            if (i == 15) irq_ack = 2'b10;
            if (i >= 8 && i < 16) begin
                wr_en = 1'b1; wr_addr = AW'(i - 8); wr_data = VEC[i + 8][7:4];
            end
            @(negedge clk);
            host_idle();
            check(pulse == 3'b000, "R2 pulse width", pulse, 0);
        end

        // half 1 not refilled: dark slots
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            check(pulse == 3'b000, "R8 dark slot", pulse, 0);
            if (k == 2) check(sym_bus == 4'h0, "R8 sym_bus blank", sym_bus, 0);
        end
        check(underrun == 1'b1, "R8 underrun set", underrun, 1);
        check(irq == 2'b01, "R7 irq held unacked", irq, 1);

        // stop
        enable = 1'b0;
        repeat (10) @(negedge clk);
        check(irq == 2'b00, "R9 stop clears irq", irq, 0);
        check(pulse == 3'b000, "R9 idle no pulse", pulse, 0);
        check(underrun == 1'b1, "R8 underrun sticky", underrun, 1);

        // restart from address 0 with new data there
        wr_en = 1'b1; wr_addr = '0; wr_data = 4'h9; valid_set = 2'b11;
        @(negedge clk);
        host_idle();
        enable = 1'b1;
        wait_pulse(n);
        check(n <= 6, "R9 restart latency", n, 6);
        check(sym_bus == 4'h9, "R9 R5 restart at addr 0", sym_bus, 9);
        check(pulse == 3'b111, "R3 restart pulse", pulse, 7);
        enable = 1'b0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            check(pulse == 3'b000, "R9 stop at slot end", pulse, 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule